// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Overrun Lockout

This block takes 8-bit frames from a clock-synchronous serial link and hands them to a host through a small register interface. The serial clock either arrives on an input pin or is produced by the block itself from the system clock, selected by a control bit. Each bit is sampled on a rising serial-clock edge and enters a shift register, least significant bit first. When eight bits have been gathered, the byte moves to a receive data register and a receive-full flag rises.

When a frame completes and the host has not yet cleared the receive-full flag, the new byte is dropped and an overrun flag is set. The receiver then stays locked: it ignores the serial clock until the host has cleared every status flag. Two level interrupt outputs, one for data and one for errors, are gated by an interrupt enable bit.

The host clears a flag by first reading it as 1 from the status register and then writing 0 to that bit. The framing and parity error bits exist so that this clear sequence covers all four flags, but this synchronous receiver never sets them.

Top module: `sync_serial_rx`

## Requirements
- R1: A frame is 8 bits sampled on rising serial-clock edges, the first bit received being bit 0 and the last bit 7; the assembled byte reads back from register address 0.
- R2: When a frame completes while the receive-full flag (status bit 0, address 1) is 0, the byte is loaded into the data register and the flag becomes 1.
- R3: `irq_rx` is 1 exactly while the interrupt enable (control bit 0, address 2) is 1, receive-full is 1 and no error flag is 1.
- R4: When a frame completes while receive-full is 1, the overrun flag (status bit 1) becomes 1, the data register keeps its old byte and receive-full stays 1.
- R5: `irq_err` is 1 exactly while the interrupt enable is 1 and any error flag (status bits 1 to 3) is 1; it is never 1 together with `irq_rx`.
- R6: After an overrun, serial clock edges are ignored until all four status flags are 0; a frame sent during this time changes neither the data register nor any flag.
- R7: A flag is cleared only by writing 0 to its status bit after a status read returned it as 1; writing 0 without that read, writing 1, or reading the data register leaves it unchanged.
- R8: The framing error (status bit 2) and parity error (status bit 3) bits always read 0.
- R9: While receive enable (control bit 1) is 0 the bit count is held at zero, so a partial frame is discarded and the next frame starts at the first rising edge after enabling.
- R10: With internal clock (control bit 2) and receive enable both 1, `sclk_oe` is 1 and `sclk_out` runs with a period of 2*DIV_HALF system clocks, data being sampled as it rises; `sclk_oe` follows control bit 2.
- R11: After reset all registers and status flags read 0 and both interrupts and `sclk_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | External serial clock |
| sdata_in | input | 1 | Serial data |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Drive enable for the generated clock |
| host_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected register |
| irq_rx | output | 1 | Receive-data interrupt, level |
| irq_err | output | 1 | Receive-error interrupt, level |

## Verification
On every cycle the assertions check that the data register never changes while receive-full is set, that an overrun only arises on a full register, that receive-full only falls after a host status write, that no frame completes while locked, and that the two interrupts never coincide. The exact byte order, the full sweep of all 256 values, the read-then-write clearing rule, discarding of a partial frame and the generated clock period can only be shown by the bench scenarios, which drive serial frames and compare register reads against the sent values.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    localparam int STAT_W = 4;
    localparam int CTRL_W = 3;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_CTRL = 2'd2
    } reg_sel_e;

    // status bit order: 3 parity, 2 framing, 1 overrun, 0 full
    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic overrun;
        logic full;
    } rx_flags_t;

    // control bit order: 2 internal clock, 1 receive enable, 0 interrupt enable
    typedef struct packed {
        logic clk_int;
        logic rx_en;
        logic rie;
    } rx_ctrl_t;

    function automatic logic any_error(input rx_flags_t f);
        return f.overrun | f.frm_err | f.par_err;
    endfunction

endpackage

// File: rtl/srx_clk_front.sv
module srx_clk_front #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_HALF    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic use_int,
    input  logic run_int,
    input  logic sclk_in,
    input  logic sdata_in,
    output logic sclk_out,
    output logic sclk_oe,
    output logic sample_stb,
    output logic sample_bit
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0]  ck_sync;
    logic [TOP:0]  dt_sync;
    logic          ck_prev;
    logic          ext_rise;
    logic [CW-1:0] div_cnt;
    logic          sclk_r;
    logic          int_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_sync <= '0;
            dt_sync <= '0;
            ck_prev <= 1'b0;
        end else begin
            ck_sync <= {ck_sync[TOP-1:0], sclk_in};
            dt_sync <= {dt_sync[TOP-1:0], sdata_in};
            ck_prev <= ck_sync[TOP];
        end
    end

    assign ext_rise = ck_sync[TOP] & ~ck_prev;

    always_ff @(posedge clk) begin
        if (rst || !run_int) begin
            div_cnt <= '0;
            sclk_r  <= 1'b0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
            sclk_r  <= ~sclk_r;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign int_rise   = run_int & (div_cnt == LAST) & ~sclk_r;
    assign sample_stb = use_int ? int_rise : ext_rise;
    assign sample_bit = dt_sync[TOP];
    assign sclk_out   = sclk_r;
    assign sclk_oe    = use_int;

    // R10
    idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
        !run_int |=> !sclk_out);

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         sample_stb,
    input  logic         sample_bit,
    output logic         frame_done,
    output logic [W-1:0] frame_byte
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  shreg;
    logic [W-1:0]  shifted;

    assign shifted = {sample_bit, shreg[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
            frame_byte <= '0;
        end else if (!enable) begin
            bit_cnt    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (sample_stb) begin
                shreg <= shifted;
                if (bit_cnt == LAST) begin
                    bit_cnt    <= '0;
                    frame_done <= 1'b1;
                    frame_byte <= shifted;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R1
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R9
    disabled_done_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !frame_done);

endmodule

// File: rtl/srx_regs.sv
module srx_regs
    import sync_rx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   host_addr,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic [W-1:0] host_wdata,
    input  logic         frame_done,
    input  logic [W-1:0] frame_byte,
    output logic [W-1:0] host_rdata,
    output rx_ctrl_t     ctrl,
    output logic         lock,
    output logic         irq_rx,
    output logic         irq_err
);
    rx_flags_t          flg, flg_n;
    logic [STAT_W-1:0]  seen, seen_n, clr;
    logic [W-1:0]       rdr;
    logic               lock_n;
    logic               stat_rd, stat_wr, ctrl_wr;
    logic               accept, ovr;
    logic               unused_wdata;

    assign unused_wdata = ^host_wdata[W-1:CTRL_W];

    assign stat_rd = host_rd & (host_addr == REG_STAT);
    assign stat_wr = host_wr & (host_addr == REG_STAT);
    assign ctrl_wr = host_wr & (host_addr == REG_CTRL);
    assign accept  = frame_done & ~flg.full;
    assign ovr     = frame_done &  flg.full;
    assign clr     = {STAT_W{stat_wr}} & ~host_wdata[STAT_W-1:0] & seen;

    always_comb begin
        flg_n         = flg;
        flg_n.full    = accept | (flg.full & ~clr[0]);
        flg_n.overrun = ovr    | (flg.overrun & ~clr[1]);
        flg_n.frm_err = flg.frm_err & ~clr[2];
        flg_n.par_err = flg.par_err & ~clr[3];
        seen_n = (seen | (stat_rd ? flg : '0)) & ~clr & flg_n;
        lock_n = (lock | ovr | any_error(flg_n)) & (|flg_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg  <= '0;
            seen <= '0;
            rdr  <= '0;
            ctrl <= '0;
            lock <= 1'b0;
        end else begin
            flg  <= flg_n;
            seen <= seen_n;
            lock <= lock_n;
            if (accept)  rdr  <= frame_byte;
            if (ctrl_wr) ctrl <= rx_ctrl_t'(host_wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        case (host_addr)
            REG_DATA: host_rdata = rdr;
            REG_STAT: host_rdata = {{(W-STAT_W){1'b0}}, flg};
            REG_CTRL: host_rdata = {{(W-CTRL_W){1'b0}}, ctrl};
            default:  host_rdata = '0;
        endcase
    end

    assign irq_rx  = ctrl.rie & flg.full & ~any_error(flg);
    assign irq_err = ctrl.rie & any_error(flg);

    // R2
    rdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(flg.full) |-> $stable(rdr));

    // R4
    overrun_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flg.overrun) |-> ($past(flg.full) && flg.full));

    // R7
    full_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flg.full) |-> ($past(host_wr) && $past(host_addr) == REG_STAT));

    // R6
    lock_frame_chk: assert property (@(posedge clk) disable iff (rst)
        lock |-> !frame_done);

    // R5
    irq_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_rx && irq_err));

    // R8
    spare_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !flg.frm_err && !flg.par_err);

endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import sync_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_HALF    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              sdata_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq_rx,
    output logic              irq_err
);
    rx_ctrl_t          ctrl;
    logic              lock;
    logic              rx_run;
    logic              stb;
    logic              sbit;
    logic              frame_done;
    logic [DATA_W-1:0] frame_byte;

    assign rx_run = ctrl.rx_en & ~lock;

    srx_clk_front #(
        .SYNC_STAGES (SYNC_STAGES),
        .DIV_HALF    (DIV_HALF)
    ) u_front (
        .clk        (clk),
        .rst        (rst),
        .use_int    (ctrl.clk_int),
        .run_int    (rx_run & ctrl.clk_int),
        .sclk_in    (sclk_in),
        .sdata_in   (sdata_in),
        .sclk_out   (sclk_out),
        .sclk_oe    (sclk_oe),
        .sample_stb (stb),
        .sample_bit (sbit)
    );

    srx_shifter #(.W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .enable     (rx_run),
        .sample_stb (stb),
        .sample_bit (sbit),
        .frame_done (frame_done),
        .frame_byte (frame_byte)
    );

    srx_regs #(.W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .frame_done (frame_done),
        .frame_byte (frame_byte),
        .host_rdata (host_rdata),
        .ctrl       (ctrl),
        .lock       (lock),
        .irq_rx     (irq_rx),
        .irq_err    (irq_err)
    );

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.rie |-> (!irq_rx && !irq_err));

endmodule

// File: tb/sync_serial_rx_bench.sv
module sync_serial_rx_bench;
    localparam int DIV_HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk_in = 1'b0;
    logic       sdata_in = 1'b0;
    logic       sclk_out, sclk_oe;
    logic [1:0] host_addr = 2'd0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       irq_rx, irq_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sync_serial_rx #(.DIV_HALF(DIV_HALF)) u_sync_serial_rx (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sdata_in = v[i];
            repeat (3) @(negedge clk); sclk_in = 1'b1;
            repeat (3) @(negedge clk); sclk_in = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (3) @(negedge clk); sclk_in = 1'b1;
            repeat (3) @(negedge clk); sclk_in = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    // read status then write 0 to the bits in mask
    task automatic clear(input logic [7:0] mask);
        logic [7:0] d;
        rd(2'd1, d);
        wr(2'd1, ~mask);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int t0, t1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd(2'd1, d); chk("R11 status", d, 0);
        rd(2'd2, d); chk("R11 ctrl", d, 0);
        rd(2'd0, d); chk("R11 data", d, 0);
        chk("R11 irq_rx", irq_rx, 0);
        chk("R11 irq_err", irq_err, 0);
        chk("R11 sclk_oe", sclk_oe, 0);

        wr(2'd2, 8'h03);
        // R1 R2 R3 R7: sweep of every byte value
        for (int v = 0; v < 256; v++) begin
            send(8'(v), 8);
            chk("R3 irq_rx on", irq_rx, 1);
            rd(2'd0, d); chk("R1 data", d, v);
            rd(2'd0, d);
            rd(2'd1, d); chk("R2 full after frame", d, 8'h01);
            wr(2'd1, 8'h00);
            rd(2'd1, d); chk("R7 cleared", d, 0);
            chk("R3 irq_rx off", irq_rx, 0);
        end

        // R7: clear without read, write of 1, data read
        send(8'hA5, 8);
        wr(2'd1, 8'h00);
        chk("R7 no clear without read", irq_rx, 1);
        rd(2'd0, d);
        rd(2'd1, d); chk("R7 status still full", d, 8'h01);
        wr(2'd1, 8'hFF);
        rd(2'd1, d); chk("R7 write 1 no effect", d, 8'h01);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R7 clear after read", d, 0);

        // R4 R5 R8 overrun
        send(8'h3C, 8);
        send(8'hC3, 8);
        rd(2'd1, d); chk("R4 overrun status", d, 8'h03);
        chk("R8 spare bits zero", d & 8'h0C, 0);
        rd(2'd0, d); chk("R4 data kept", d, 8'h3C);
        chk("R5 irq_err", irq_err, 1);
        chk("R5 irq_rx masked", irq_rx, 0);

        // R6 lockout
        send(8'h55, 8);
        rd(2'd1, d); chk("R6 locked status", d, 8'h03);
        rd(2'd0, d); chk("R6 locked data", d, 8'h3C);
        wr(2'd1, 8'h01);
        rd(2'd1, d); chk("R6 overrun cleared", d, 8'h01);
        chk("R5 irq_err off", irq_err, 0);
        send(8'h55, 8);
        rd(2'd1, d); chk("R6 still locked status", d, 8'h01);
        rd(2'd0, d); chk("R6 still locked data", d, 8'h3C);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R6 all clear", d, 0);
        send(8'h99, 8);
        rd(2'd0, d); chk("R6 resumes", d, 8'h99);
        clear(8'h01);

        // R3 interrupt enable off
        wr(2'd2, 8'h02);
        send(8'h12, 8);
        chk("R3 rie off", irq_rx, 0);
        clear(8'h01);

        // R9 partial frame discarded
        wr(2'd2, 8'h03);
        send(8'hFF, 3);
        wr(2'd2, 8'h01);
        edges(5);
        rd(2'd1, d); chk("R9 disabled no frame", d, 0);
        wr(2'd2, 8'h03);
        send(8'h81, 8);
        rd(2'd0, d); chk("R9 fresh frame", d, 8'h81);
        clear(8'h01);

        // R10 internal clock
        foreach (d[k]) begin end
        for (int n = 0; n < 2; n++) begin
            logic [7:0] v;
            v = (n == 0) ? 8'h6D : 8'hB2;
            @(negedge clk); sdata_in = v[0];
            wr(2'd2, 8'h07);
            chk("R10 sclk_oe", sclk_oe, 1);
            t0 = 0; t1 = 0;
            for (int i = 1; i < 8; i++) begin
                @(negedge sclk_out); sdata_in = v[i];
                if (i == 1) begin @(posedge sclk_out); t0 = cyc; end
                if (i == 2) begin @(posedge sclk_out); t1 = cyc; end
            end
            @(posedge sclk_out);
            wr(2'd2, 8'h01);
            repeat (4) @(negedge clk);
            chk("R10 period", t1 - t0, 2 * DIV_HALF);
            rd(2'd0, d); chk("R10 data", d, v);
            chk("R10 irq_rx", irq_rx, 1);
            clear(8'h01);
        end
        chk("R10 sclk_oe off", sclk_oe, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule